// File: doc/BRIEF.md
# Byte-and-Pair Register File

This block holds the register state of a small 8-bit processor. There is an accumulator, six general byte registers that combine into three 16-bit pairs, a flags byte and a separate 16-bit stack pointer. A datapath reads any register as a single byte, or as a 16-bit pair, through combinational read ports. It changes the state with one operation per clock, given by an operation code, the register or pair select codes and the write data, and qualified by a strobe.

The operations cover what the datapath needs at pair level. It can write a byte or a pair. It can increment or decrement a pair as one 16-bit number. It can swap the two addressing pairs, copy the memory-address pair into the stack pointer, and add any pair into the memory-address pair, which updates the carry flag. Decoding instructions, the 8-bit arithmetic unit and the bus are handled elsewhere.

Top module: `pairreg_file`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every byte register, the flags byte and the stack pointer to zero.
- R2: Byte codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=flags and 7=accumulator. Operation code 0 writes wr_byte into the register named by byte_sel. In the flags byte, bits 5, 3 and 1 always read 0, whatever value was written.
- R3: Pair codes are 0=BC, 1=DE, 2=HL and 3. Code 3 reads as the stack pointer when the mode bit is 0, and as {accumulator, flags} when the mode bit is 1. In each pair the first-named register is the high byte.
- R4: Operation code 1 writes wr_pair into the pair named by pair_sel and pair_mode. The high byte goes to the first register and the low byte to the second. A write to {accumulator, flags} obeys the flag-bit rule of R2.
- R5: Operation codes 2 and 3 increment and decrement the selected pair, modulo 65536. For these operations pair code 3 always means the stack pointer. The flags do not change.
- R6: Operation code 4 swaps DE and HL in one clock.
- R7: Operation code 5 copies HL into the stack pointer and leaves HL unchanged.
- R8: Operation code 6 adds the selected pair (code 3 means the stack pointer) to HL and writes the low 16 bits back into HL. It sets the carry flag (flags bit 0) to the carry out of bit 15 and leaves every other flag bit unchanged.
- R9: Nothing changes while op_valid is low, or when the operation code is 7.
- R10: Both read ports are combinational. A written value becomes visible on the reads right after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation code (see R2 to R9) |
| byte_sel | input | 3 | Byte register select for byte writes |
| pair_sel | input | 2 | Pair select for pair operations |
| pair_mode | input | 1 | Selects what pair code 3 means for pair writes (0 stack pointer, 1 accumulator/flags) |
| wr_byte | input | 8 | Byte write data |
| wr_pair | input | 16 | Pair write data |
| rd_byte_sel | input | 3 | Byte read select |
| rd_pair_sel | input | 2 | Pair read select |
| rd_pair_mode | input | 1 | What pair code 3 means on the read port |
| rd_byte | output | 8 | Selected byte |
| rd_pair | output | 16 | Selected pair |

## Verification
The hardest case is the add into HL with a carry out of bit 15, with the other flag bits still visible. The carry can only be seen through the accumulator/flags read view. So the stimulus first loads nonzero, hole-free flags, then drives HL to all ones through a decrement that wraps. It then adds a pair that forces the carry, and then adds HL to itself and adds the stack pointer, both of which clear it. It also checks that mode 1 is ignored on a stack-pointer decrement, and that a reserved operation code with its strobe high changes nothing.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;

    localparam int OP_W       = 3;
    localparam int BSEL_W     = 3;
    localparam int PSEL_W     = 2;
    localparam int NUM_BYTES  = 8;
    localparam int NUM_GPAIRS = 3;

    localparam logic [BSEL_W-1:0] IDX_H     = 3'd4;
    localparam logic [BSEL_W-1:0] IDX_L     = 3'd5;
    localparam logic [BSEL_W-1:0] IDX_D     = 3'd2;
    localparam logic [BSEL_W-1:0] IDX_E     = 3'd3;
    localparam logic [BSEL_W-1:0] IDX_FLAGS = 3'd6;
    localparam logic [BSEL_W-1:0] IDX_ACC   = 3'd7;

    localparam logic [PSEL_W-1:0] PAIR_TOP  = 2'd3;

    typedef enum logic [OP_W-1:0] {
        OP_WR_BYTE = 3'd0,
        OP_WR_PAIR = 3'd1,
        OP_INC     = 3'd2,
        OP_DEC     = 3'd3,
        OP_SWAP    = 3'd4,
        OP_LOAD_SP = 3'd5,
        OP_ADD_HL  = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

endpackage

// File: rtl/pairreg_read_mux.sv
module pairreg_read_mux
    import pairreg_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic [NUM_BYTES-1:0][DATA_W-1:0] regs,
    input  logic [PAIR_W-1:0]                sp,
    input  logic [BSEL_W-1:0]                byte_sel,
    input  logic [PSEL_W-1:0]                pair_sel,
    input  logic                             pair_mode,
    output logic [DATA_W-1:0]                byte_val,
    output logic [PAIR_W-1:0]                pair_val
);

    logic [PAIR_W-1:0] view [NUM_GPAIRS+1];

    for (genvar g = 0; g < NUM_GPAIRS; g++) begin : g_gpair
        assign view[g] = {regs[2*g], regs[2*g+1]};
    end

    assign view[NUM_GPAIRS] = pair_mode ? {regs[IDX_ACC], regs[IDX_FLAGS]} : sp;

    assign byte_val = regs[byte_sel];
    assign pair_val = view[pair_sel];

endmodule

// File: rtl/pairreg_pair_alu.sv
module pairreg_pair_alu #(
    parameter int PAIR_W = 16
) (
    input  logic [PAIR_W-1:0] operand,
    input  logic [PAIR_W-1:0] hl,
    output logic [PAIR_W-1:0] inc_val,
    output logic [PAIR_W-1:0] dec_val,
    output logic [PAIR_W-1:0] sum_val,
    output logic              sum_carry
);

    logic [PAIR_W:0] wide_sum;

    always_comb begin
        inc_val  = operand + PAIR_W'(1);
        dec_val  = operand - PAIR_W'(1);
        wide_sum = {1'b0, operand} + {1'b0, hl};
        sum_val  = wide_sum[PAIR_W-1:0];
        sum_carry = wide_sum[PAIR_W];
    end

endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
    import pairreg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] FLAG_HOLES = 8'h2A,
    parameter int CARRY_POS = 0,
    localparam int PAIR_W = 2 * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_code,
    input  logic [BSEL_W-1:0]   byte_sel,
    input  logic [PSEL_W-1:0]   pair_sel,
    input  logic                pair_mode,
    input  logic [DATA_W-1:0]   wr_byte,
    input  logic [PAIR_W-1:0]   wr_pair,
    input  logic [BSEL_W-1:0]   rd_byte_sel,
    input  logic [PSEL_W-1:0]   rd_pair_sel,
    input  logic                rd_pair_mode,
    output logic [DATA_W-1:0]   rd_byte,
    output logic [PAIR_W-1:0]   rd_pair
);

    typedef struct packed {
        logic [NUM_BYTES-1:0][DATA_W-1:0] regs;
        logic [PAIR_W-1:0]                sp;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] unused_byte;
    logic [PAIR_W-1:0] op_pair;
    logic [PAIR_W-1:0] hl_q, de_q;
    logic [PAIR_W-1:0] inc_val, dec_val, sum_val;
    logic              sum_carry;

    logic              pw_en;
    logic [PSEL_W-1:0] pw_sel;
    logic              pw_mode;
    logic [PAIR_W-1:0] pw_val;

    assign hl_q = {st_q.regs[IDX_H], st_q.regs[IDX_L]};
    assign de_q = {st_q.regs[IDX_D], st_q.regs[IDX_E]};

    // external read port
    pairreg_read_mux #(.DATA_W(DATA_W)) u_rd_port (
        .regs      (st_q.regs),
        .sp        (st_q.sp),
        .byte_sel  (rd_byte_sel),
        .pair_sel  (rd_pair_sel),
        .pair_mode (rd_pair_mode),
        .byte_val  (rd_byte),
        .pair_val  (rd_pair)
    );

    // operand fetch: pair code 3 is always the stack pointer here
    pairreg_read_mux #(.DATA_W(DATA_W)) u_op_port (
        .regs      (st_q.regs),
        .sp        (st_q.sp),
        .byte_sel  (byte_sel),
        .pair_sel  (pair_sel),
        .pair_mode (1'b0),
        .byte_val  (unused_byte),
        .pair_val  (op_pair)
    );

    pairreg_pair_alu #(.PAIR_W(PAIR_W)) u_alu (
        .operand   (op_pair),
        .hl        (hl_q),
        .inc_val   (inc_val),
        .dec_val   (dec_val),
        .sum_val   (sum_val),
        .sum_carry (sum_carry)
    );

    // pair write selection
    always_comb begin
        pw_en   = 1'b0;
        pw_sel  = pair_sel;
        pw_mode = 1'b0;
        pw_val  = '0;
        if (op_valid) begin
            unique case (op_e'(op_code))
                OP_WR_PAIR: begin pw_en = 1'b1; pw_mode = pair_mode; pw_val = wr_pair; end
                OP_INC:     begin pw_en = 1'b1; pw_val = inc_val; end
                OP_DEC:     begin pw_en = 1'b1; pw_val = dec_val; end
                default:    ;
            endcase
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (pw_en) begin
            if (pw_sel != PAIR_TOP) begin
                st_d.regs[{pw_sel, 1'b0}] = pw_val[PAIR_W-1:DATA_W];
                st_d.regs[{pw_sel, 1'b1}] = pw_val[DATA_W-1:0];
            end else if (pw_mode) begin
                st_d.regs[IDX_ACC]   = pw_val[PAIR_W-1:DATA_W];
                st_d.regs[IDX_FLAGS] = pw_val[DATA_W-1:0] & ~FLAG_HOLES;
            end else begin
                st_d.sp = pw_val;
            end
        end
        if (op_valid) begin
            unique case (op_e'(op_code))
                OP_WR_BYTE: begin
                    if (byte_sel == IDX_FLAGS)
                        st_d.regs[byte_sel] = wr_byte & ~FLAG_HOLES;
                    else
                        st_d.regs[byte_sel] = wr_byte;
                end
                OP_SWAP: begin
                    st_d.regs[IDX_D] = st_q.regs[IDX_H];
                    st_d.regs[IDX_E] = st_q.regs[IDX_L];
                    st_d.regs[IDX_H] = st_q.regs[IDX_D];
                    st_d.regs[IDX_L] = st_q.regs[IDX_E];
                end
                OP_LOAD_SP: st_d.sp = hl_q;
                OP_ADD_HL: begin
                    st_d.regs[IDX_H] = sum_val[PAIR_W-1:DATA_W];
                    st_d.regs[IDX_L] = sum_val[DATA_W-1:0];
                    st_d.regs[IDX_FLAGS][CARRY_POS] = sum_carry;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    function automatic logic [PAIR_W-1:0] pair_of(state_t s, logic [PSEL_W-1:0] sel);
        if (sel == PAIR_TOP) return s.sp;
        return {s.regs[{sel, 1'b0}], s.regs[{sel, 1'b1}]};
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) $rose(rst_n) |-> st_q == '0);

    assert_flag_holes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.regs[IDX_FLAGS] & FLAG_HOLES) == '0);

    assert_incdec_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_INC || op_code == OP_DEC) |=> $stable(st_q.regs[IDX_FLAGS]));

    assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_INC |=>
        pair_of(st_q, $past(pair_sel)) == PAIR_W'($past(op_pair) + 1'b1));

    assert_swap_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_SWAP |=> hl_q == $past(de_q) && de_q == $past(hl_q));

    assert_sp_from_hl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_LOAD_SP |=> st_q.sp == $past(hl_q) && $stable(hl_q));

    assert_add_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_ADD_HL |=>
        {st_q.regs[IDX_FLAGS][CARRY_POS], hl_q} == ({1'b0, $past(hl_q)} + {1'b0, $past(op_pair)}));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == OP_RSVD) |=> $stable(st_q));

endmodule

// File: tb/tb_pairreg_file.sv
`timescale 1ns/1ps
module tb_pairreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [2:0]  byte_sel = '0;
    logic [1:0]  pair_sel = '0;
    logic        pair_mode = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic [15:0] wr_pair = '0;
    logic [2:0]  rd_byte_sel = '0;
    logic [1:0]  rd_pair_sel = '0;
    logic        rd_pair_mode = 1'b0;
    logic [7:0]  rd_byte;
    logic [15:0] rd_pair;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pairreg_file dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .byte_sel(byte_sel), .pair_sel(pair_sel), .pair_mode(pair_mode),
        .wr_byte(wr_byte), .wr_pair(wr_pair), .rd_byte_sel(rd_byte_sel),
        .rd_pair_sel(rd_pair_sel), .rd_pair_mode(rd_pair_mode),
        .rd_byte(rd_byte), .rd_pair(rd_pair)
    );

    typedef struct packed {
        logic        valid;
        logic [2:0]  op;
        logic [2:0]  bsel;
        logic [1:0]  psel;
        logic        mode;
        logic [15:0] wdata;
        logic [1:0]  csel;
        logic        cmode;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    // ops: 0 byte wr, 1 pair wr, 2 inc, 3 dec, 4 swap, 5 load sp, 6 add hl, 7 reserved
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd1, 3'd0, 2'd0, 1'b0, 16'h1234, 2'd0, 1'b0, 16'h1234, 4'd4},  // R4 BC
        '{1'b1, 3'd1, 3'd0, 2'd1, 1'b0, 16'h5678, 2'd1, 1'b0, 16'h5678, 4'd4},  // R4 DE
        '{1'b1, 3'd1, 3'd0, 2'd2, 1'b0, 16'hFFFF, 2'd2, 1'b0, 16'hFFFF, 4'd4},  // R4 HL
        '{1'b1, 3'd1, 3'd0, 2'd3, 1'b0, 16'h0100, 2'd3, 1'b0, 16'h0100, 4'd4},  // R4 SP
        '{1'b1, 3'd0, 3'd7, 2'd0, 1'b0, 16'h009A, 2'd3, 1'b1, 16'h9A00, 4'd2},  // R2 acc
        '{1'b1, 3'd0, 3'd6, 2'd0, 1'b0, 16'h00FF, 2'd3, 1'b1, 16'h9AD5, 4'd2},  // R2 holes
        '{1'b1, 3'd0, 3'd6, 2'd0, 1'b0, 16'h00C4, 2'd3, 1'b1, 16'h9AC4, 4'd2},  // R2 flags
        '{1'b1, 3'd2, 3'd0, 2'd2, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h0000, 4'd5},  // R5 inc wraps
        '{1'b0, 3'd2, 3'd0, 2'd2, 1'b0, 16'h0000, 2'd3, 1'b1, 16'h9AC4, 4'd5},  // R5 flags kept
        '{1'b1, 3'd3, 3'd0, 2'd2, 1'b0, 16'h0000, 2'd2, 1'b0, 16'hFFFF, 4'd5},  // R5 dec wraps
        '{1'b1, 3'd6, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h1233, 4'd8},  // R8 sum
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd3, 1'b1, 16'h9AC5, 4'd8},  // R8 carry set
        '{1'b1, 3'd6, 3'd0, 2'd2, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h2466, 4'd8},  // R8 hl+hl
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd3, 1'b1, 16'h9AC4, 4'd8},  // R8 carry clear
        '{1'b1, 3'd4, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd1, 1'b0, 16'h2466, 4'd6},  // R6 DE
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h5678, 4'd6},  // R6 HL
        '{1'b1, 3'd5, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd3, 1'b0, 16'h5678, 4'd7},  // R7 SP
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd2, 1'b0, 16'h5678, 4'd7},  // R7 HL kept
        '{1'b1, 3'd3, 3'd0, 2'd3, 1'b1, 16'h0000, 2'd3, 1'b0, 16'h5677, 4'd5},  // R5 SP, mode ignored
        '{1'b1, 3'd2, 3'd0, 2'd1, 1'b0, 16'h0000, 2'd1, 1'b0, 16'h2467, 4'd5},  // R5 DE inc
        '{1'b1, 3'd1, 3'd0, 2'd3, 1'b1, 16'h1BFF, 2'd3, 1'b1, 16'h1BD5, 4'd4},  // R4 AF write
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd3, 1'b0, 16'h5677, 4'd3},  // R3 SP view
        '{1'b1, 3'd7, 3'd7, 2'd0, 1'b1, 16'hFFFF, 2'd0, 1'b0, 16'h1234, 4'd9},  // R9 reserved
        '{1'b1, 3'd6, 3'd0, 2'd3, 1'b1, 16'h0000, 2'd2, 1'b0, 16'hACEF, 4'd8},  // R8 add SP
        '{1'b0, 3'd0, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd3, 1'b1, 16'h1BD4, 4'd8},  // R8 carry clear
        '{1'b1, 3'd1, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b0, 16'h0000, 4'd4},  // R4 BC zero
        '{1'b1, 3'd3, 3'd0, 2'd0, 1'b0, 16'h0000, 2'd0, 1'b0, 16'hFFFF, 4'd5},  // R5 BC wraps down
        '{1'b0, 3'd1, 3'd0, 2'd0, 1'b0, 16'h1111, 2'd0, 1'b0, 16'hFFFF, 4'd9}   // R9 strobe low
    };

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] final_bytes [8];
        final_bytes = '{8'hFF, 8'hFF, 8'h24, 8'h67, 8'hAC, 8'hEF, 8'hD4, 8'h1B};

        // R1: reset state
        repeat (3) @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            rd_pair_sel = 2'(p);
            rd_pair_mode = 1'b0;
            #0.5 check16("R1", rd_pair, 16'h0000);
        end
        rd_pair_mode = 1'b1;
        rd_pair_sel = 2'd3;
        #0.5 check16("R1", rd_pair, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid  = VECS[i].valid;
            op_code   = VECS[i].op;
            byte_sel  = VECS[i].bsel;
            pair_sel  = VECS[i].psel;
            pair_mode = VECS[i].mode;
            wr_byte   = VECS[i].wdata[7:0];
            wr_pair   = VECS[i].wdata;
            @(posedge clk);
            #1;
            rd_pair_sel  = VECS[i].csel;
            rd_pair_mode = VECS[i].cmode;
            #1;
            check16($sformatf("R%0d vec %0d", VECS[i].req, i), rd_pair, VECS[i].exp);
        end
        @(negedge clk);
        op_valid = 1'b0;

        // R2 and R10: every byte read, select changes without a clock edge
        for (int b = 0; b < 8; b++) begin
            rd_byte_sel = 3'(b);
            #0.2 check8("R2 R10 byte read", rd_byte, final_bytes[b]);
        end
        // R3: pair views composed high/low
        rd_pair_sel = 2'd1; rd_pair_mode = 1'b1;
        #0.2 check16("R3 DE view", rd_pair, 16'h2467);

        // R10: a write is visible right after its edge
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd0; byte_sel = 3'd2; wr_byte = 8'h5A;
        rd_byte_sel = 3'd2;
        #0.5 check8("R10 before edge", rd_byte, 8'h24);
        @(posedge clk);
        #0.5 check8("R10 after edge", rd_byte, 8'h5A);
        @(negedge clk);
        op_valid = 1'b0;

        // R1: reset in mid-run clears everything
        rst_n = 1'b0;
        #0.5;
        rd_pair_sel = 2'd3; rd_pair_mode = 1'b0;
        #0.5 check16("R1 sp after reset", rd_pair, 16'h0000);
        rd_pair_mode = 1'b1;
        #0.5 check16("R1 af after reset", rd_pair, 16'h0000);
        rd_pair_sel = 2'd2;
        #0.5 check16("R1 hl after reset", rd_pair, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule